// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block is the status register of an I2C controller, seen from the CPU side. It keeps eight bits:

- seven sticky event flags, each with its own set and clear sources;
- one acknowledge bit that software can read and write.

The flags are driven by one-cycle event pulses that the rest of the controller produces: start and stop detection, address comparator matches, data-register empty and full events, and SCL edges. The arbitration-lost comparison is made inside the block, from the internal and pin levels of SDA and SCL.

The CPU reads the register combinationally on `rdata_o` and pulses `rd_i` to mark that read. For a flag to clear, two things must happen in order: a read that returned 1 for that bit, then a later write of 0 to it. Access to the data register also clears the arbitration-lost and address flags. Clearing the interrupt flag clears the two stop flags and the continuous-transfer flag. The acknowledge bit sets the level driven in the acknowledge slot when receiving. When transmitting, it captures the level the receiver returns.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset all eight bits read 0. Bit positions in `rdata_o`, from bit 7 down to bit 0, are: error-stop, normal-stop, continuous-transfer, second-address-match, arbitration-lost, address-match, general-call, ack.
- R2: A write clears bit b (7..1) only if `wdata_i[b]`=0 and the most recent `rd_i` pulse before it returned 1 in bit b, with no write in between. Writing 1 to bits 7..1 has no effect. A write of 0 that no read has qualified has no effect. Each write consumes all qualifications.
- R3: Every write loads `wdata_i[0]` into the ack bit (bit 0), and `ack_o` always equals bit 0.
- R4: Arbitration-lost (bit 3) sets only when `master_i`=1 and `transmit_i`=1, on either of two conditions: `scl_rise_i` arrives while `sda_int_i`≠`sda_pin_i`, or `scl_fall_i` arrives while `scl_int_i`=1.
- R5: Bits 3, 2 and 1 clear on `dr_wr_i` while `transmit_i`=1, or on `dr_rd_i` while `transmit_i`=0.
- R6: While `master_i`=1, bits 4, 2 and 1 are forced to 0. `start_det_i` clears bit 4.
- R7: `stop_det_i` in slave mode (`master_i`=0) sets bit 7 if `frame_busy_i`=1, or sets bit 6 if `frame_busy_i`=0. `int_clr_i` clears bits 7, 6 and 5.
- R8: Bit 5 sets on `tdre_set_i` or `rdrf_set_i`. In master mode this happens always; in slave mode only while bit 4 is 1.
- R9: All three address flags need slave receive (`master_i`=0, `transmit_i`=0).
  - Bit 2 sets on `addr_match_i` or `gcall_match_i` when `fs_i`=0.
  - Bit 1 sets on `gcall_match_i` when `fs_i`=0 or `fsx_i`=0.
  - Bit 4 sets on `addr2_match_i` when `fsx_i`=0.
- R10: In an acknowledge slot (`ack_sample_i`) while `transmit_i`=1, bit 0 captures `ack_pin_i`. This takes priority over a write in the same cycle.
- R11: When a set and any clear of a flag fall in the same cycle, the flag ends at 1. The master-mode force of R6 overrides everything.
- R12: All bits update on the rising clock edge and are visible on `rdata_o` in the cycle after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| master_i | input | 1 | controller is in master mode |
| transmit_i | input | 1 | controller is transmitting (0 = receiving) |
| fs_i | input | 1 | format select for first address |
| fsx_i | input | 1 | format select for second address |
| start_det_i | input | 1 | start condition detected pulse |
| stop_det_i | input | 1 | stop condition detected pulse |
| frame_busy_i | input | 1 | a frame is in progress |
| addr_match_i | input | 1 | own slave address matched pulse |
| gcall_match_i | input | 1 | general call address matched pulse |
| addr2_match_i | input | 1 | second slave address matched pulse |
| tdre_set_i | input | 1 | transmit-empty flag set pulse |
| rdrf_set_i | input | 1 | receive-full flag set pulse |
| int_clr_i | input | 1 | interrupt flag cleared pulse |
| dr_wr_i | input | 1 | data register written |
| dr_rd_i | input | 1 | data register read |
| sda_int_i | input | 1 | internally driven SDA level |
| sda_pin_i | input | 1 | sampled SDA pin level |
| scl_int_i | input | 1 | internally driven SCL level |
| scl_rise_i | input | 1 | SCL pin rising edge pulse |
| scl_fall_i | input | 1 | SCL pin falling edge pulse |
| ack_sample_i | input | 1 | acknowledge slot pulse |
| ack_pin_i | input | 1 | SDA level in the acknowledge slot |
| rd_i | input | 1 | status register read strobe |
| wr_i | input | 1 | status register write strobe |
| wdata_i | input | 8 | status register write data |
| rdata_o | output | 8 | status register contents |
| ack_o | output | 1 | ack bit, level driven in the acknowledge slot |

## Verification
Every event, write and read qualification takes effect at the next rising edge. Its result is due on `rdata_o` and `ack_o` one cycle after the stimulus. The bench applies each stimulus 2 ns after an edge and computes the expected register from the requirements. It then steps exactly one edge and compares 2 ns later. A read qualification is checked only through the effect of the next write, which is due one cycle after that write.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned FLAG_N = STAT_W - 1;
  localparam int unsigned B_ACK  = 0;
  localparam int unsigned B_GC   = 1;
  localparam int unsigned B_AM   = 2;
  localparam int unsigned B_AL   = 3;
  localparam int unsigned B_AM2  = 4;
  localparam int unsigned B_CT   = 5;
  localparam int unsigned B_NSTP = 6;
  localparam int unsigned B_ESTP = 7;
endpackage

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk (
  input  logic en_i,
  input  logic sda_int_i,
  input  logic sda_pin_i,
  input  logic scl_int_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  output logic lost_o
);
  logic sda_miss, scl_miss;
  assign sda_miss = scl_rise_i & (sda_int_i ^ sda_pin_i);
  assign scl_miss = scl_fall_i & scl_int_i; // still driving high while bus fell
  assign lost_o   = en_i & (sda_miss | scl_miss);
endmodule

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (hold_i) q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1; // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              transmit_i,
  input  logic              fs_i,
  input  logic              fsx_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              frame_busy_i,
  input  logic              addr_match_i,
  input  logic              gcall_match_i,
  input  logic              addr2_match_i,
  input  logic              tdre_set_i,
  input  logic              rdrf_set_i,
  input  logic              int_clr_i,
  input  logic              dr_wr_i,
  input  logic              dr_rd_i,
  input  logic              sda_int_i,
  input  logic              sda_pin_i,
  input  logic              scl_int_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              ack_sample_i,
  input  logic              ack_pin_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  output logic              ack_o
);
  logic [STAT_W-1:0] stat;
  logic [FLAG_N-1:0] rd1_q, sw_clr, set_v, clr_v, hold_v;
  logic              ack_q, arb_lost, slave_rx, dr_clr;

  i2c_arb_chk u_arb (
    .en_i      (master_i & transmit_i),
    .sda_int_i (sda_int_i),
    .sda_pin_i (sda_pin_i),
    .scl_int_i (scl_int_i),
    .scl_rise_i(scl_rise_i),
    .scl_fall_i(scl_fall_i),
    .lost_o    (arb_lost)
  );

  assign slave_rx = ~master_i & ~transmit_i;
  assign dr_clr   = (dr_wr_i & transmit_i) | (dr_rd_i & ~transmit_i);
  assign sw_clr   = {FLAG_N{wr_i}} & rd1_q & ~wdata_i[STAT_W-1:1];

  always_comb begin
    set_v  = '0;
    clr_v  = sw_clr;
    hold_v = '0;
    set_v[B_GC-1]   = slave_rx & gcall_match_i & (~fs_i | ~fsx_i);
    set_v[B_AM-1]   = slave_rx & ~fs_i & (addr_match_i | gcall_match_i);
    set_v[B_AL-1]   = arb_lost;
    set_v[B_AM2-1]  = slave_rx & ~fsx_i & addr2_match_i;
    set_v[B_CT-1]   = (tdre_set_i | rdrf_set_i) & (master_i | stat[B_AM2]);
    set_v[B_NSTP-1] = ~master_i & stop_det_i & ~frame_busy_i;
    set_v[B_ESTP-1] = ~master_i & stop_det_i & frame_busy_i;
    clr_v[B_GC-1]   = sw_clr[B_GC-1] | dr_clr;
    clr_v[B_AM-1]   = sw_clr[B_AM-1] | dr_clr;
    clr_v[B_AL-1]   = sw_clr[B_AL-1] | dr_clr;
    clr_v[B_AM2-1]  = sw_clr[B_AM2-1] | start_det_i;
    clr_v[B_CT-1]   = sw_clr[B_CT-1] | int_clr_i;
    clr_v[B_NSTP-1] = sw_clr[B_NSTP-1] | int_clr_i;
    clr_v[B_ESTP-1] = sw_clr[B_ESTP-1] | int_clr_i;
    hold_v[B_GC-1]  = master_i;
    hold_v[B_AM-1]  = master_i;
    hold_v[B_AM2-1] = master_i;
  end

  for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
    i2c_flag_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[gi]),
      .clr_i (clr_v[gi]),
      .hold_i(hold_v[gi]),
      .q_o   (stat[gi+1])
    );
  end

  // read-as-1 qualification: reloaded by read, consumed by write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd1_q <= '0;
    else if (rd_i)  rd1_q <= stat[STAT_W-1:1];
    else if (wr_i)  rd1_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ack_q <= 1'b0;
    else if (ack_sample_i & transmit_i) ack_q <= ack_pin_i;
    else if (wr_i)                      ack_q <= wdata_i[B_ACK];
  end

  assign stat[B_ACK] = ack_q;
  assign rdata_o     = stat;
  assign ack_o       = ack_q;
endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       master_i,
  input logic       transmit_i,
  input logic       sda_int_i,
  input logic       sda_pin_i,
  input logic       scl_rise_i,
  input logic       stop_det_i,
  input logic       int_clr_i,
  input logic       ack_sample_i,
  input logic       ack_pin_i,
  input logic [7:0] rdata_o
);
  // R4
  al_on_sda_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && transmit_i && scl_rise_i && (sda_int_i != sda_pin_i) |=> rdata_o[3]);
  // R6
  master_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> !rdata_o[4] && !rdata_o[2] && !rdata_o[1]);
  // R7
  estop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[7]) |-> $past(stop_det_i));
  // R7
  nstop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[6]) |-> $past(stop_det_i));
  // R7
  int_clr_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_i && !stop_det_i |=> !rdata_o[7] && !rdata_o[6]);
  // R10
  ack_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_sample_i && transmit_i |=> rdata_o[0] == $past(ack_pin_i));
endmodule

bind i2c_stat_reg i2c_stat_reg_chk u_chk (.*);

// File: tb/test_i2c_stat_reg.sv
`timescale 1ns/1ps
module test_i2c_stat_reg;
  logic clk_i = 0, rst_ni = 0;
  logic master_i, transmit_i, fs_i, fsx_i, start_det_i, stop_det_i, frame_busy_i;
  logic addr_match_i, gcall_match_i, addr2_match_i, tdre_set_i, rdrf_set_i, int_clr_i;
  logic dr_wr_i, dr_rd_i, sda_int_i, sda_pin_i, scl_int_i, scl_rise_i, scl_fall_i;
  logic ack_sample_i, ack_pin_i, rd_i, wr_i, ack_o;
  logic [7:0] wdata_i, rdata_o;
  logic [7:0] m;
  logic [6:0] m_rd1;
  int total = 0, bad = 0;
  bit  done = 0;

  always #5 clk_i = ~clk_i;

  i2c_stat_reg i_i2c_stat_reg (.*);

  function automatic logic [7:0] nxt_model();
    logic [7:0] r = m;
    logic [7:0] st, cl, hd;
    logic       drc = (dr_wr_i & transmit_i) | (dr_rd_i & ~transmit_i);
    logic       srx = ~master_i & ~transmit_i;
    st = '0; cl = '0; hd = '0;
    for (int b = 1; b < 8; b++) cl[b] = wr_i & m_rd1[b-1] & ~wdata_i[b];
    st[1] = srx & gcall_match_i & (~fs_i | ~fsx_i);
    st[2] = srx & ~fs_i & (addr_match_i | gcall_match_i);
    st[3] = master_i & transmit_i & ((scl_rise_i & (sda_int_i != sda_pin_i)) | (scl_fall_i & scl_int_i));
    st[4] = srx & ~fsx_i & addr2_match_i;
    st[5] = (tdre_set_i | rdrf_set_i) & (master_i | m[4]);
    st[6] = ~master_i & stop_det_i & ~frame_busy_i;
    st[7] = ~master_i & stop_det_i & frame_busy_i;
    cl[1] |= drc; cl[2] |= drc; cl[3] |= drc; cl[4] |= start_det_i;
    cl[5] |= int_clr_i; cl[6] |= int_clr_i; cl[7] |= int_clr_i;
    hd[1] = master_i; hd[2] = master_i; hd[4] = master_i;
    for (int b = 1; b < 8; b++)
      r[b] = hd[b] ? 1'b0 : st[b] ? 1'b1 : cl[b] ? 1'b0 : m[b];
    r[0] = (ack_sample_i & transmit_i) ? ack_pin_i : wr_i ? wdata_i[0] : m[0];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_pulses();
    {start_det_i, stop_det_i, addr_match_i, gcall_match_i, addr2_match_i} = '0;
    {tdre_set_i, rdrf_set_i, int_clr_i, dr_wr_i, dr_rd_i} = '0;
    {scl_rise_i, scl_fall_i, ack_sample_i, rd_i, wr_i} = '0;
  endtask

  // apply current inputs for one edge, then compare against the model
  task automatic step(input string tag);
    logic [7:0] n = nxt_model();
    logic [6:0] r1 = rd_i ? rdata_o[7:1] : wr_i ? 7'd0 : m_rd1;
    @(posedge clk_i); #2;
    m = n; m_rd1 = r1;
    clr_pulses();
    chk(tag, rdata_o, m);
    chk(tag, {7'd0, ack_o}, {7'd0, m[0]});
  endtask

  task automatic rd_clr(input logic [7:0] wd, input string tag);
    rd_i = 1; step(tag);
    wr_i = 1; wdata_i = wd; step(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clr_pulses();
    {master_i, transmit_i, fs_i, fsx_i, frame_busy_i} = '0;
    {sda_int_i, sda_pin_i, scl_int_i, ack_pin_i} = '0;
    wdata_i = '0; m = '0; m_rd1 = '0;
    #22 chk("R1 reset", rdata_o, 8'h00);
    rst_ni = 1; #10;
    chk("R1 idle", rdata_o, 8'h00);

    // R9: address flags in slave receive
    addr_match_i = 1; step("R9 own addr");
    chk("R9 bit2", rdata_o, 8'h04);
    fs_i = 1; fsx_i = 0; gcall_match_i = 1; step("R9 gcall fs=1");
    chk("R9 bit1 only", rdata_o, 8'h06);
    addr2_match_i = 1; step("R9 addr2");
    chk("R9 bit4", rdata_o, 8'h16);
    fs_i = 0;
    // R2: write 0 without read ignored, write 1 ignored
    wr_i = 1; wdata_i = 8'h00; step("R2 unqualified");
    chk("R2 unqualified", rdata_o, 8'h16);
    rd_clr(8'hFF, "R2 write ones");
    chk("R2 write ones", rdata_o, 8'h17);
    rd_clr(8'hFB, "R2 clear bit2");
    chk("R2 clear bit2", rdata_o, 8'h13);
    wr_i = 1; wdata_i = 8'h01; step("R2 consumed");
    chk("R2 consumed", rdata_o, 8'h13);
    // R3
    wr_i = 1; wdata_i = 8'h00; step("R3 ack write");
    chk("R3 ack 0", {7'd0, ack_o}, 8'h00);
    // R8: slave with bit4=1
    rdrf_set_i = 1; step("R8 slave cont");
    chk("R8 bit5", rdata_o, 8'h32);
    // R7
    stop_det_i = 1; frame_busy_i = 1; step("R7 estop");
    stop_det_i = 1; frame_busy_i = 0; step("R7 nstop");
    chk("R7 both", rdata_o & 8'hE0, 8'hE0);
    int_clr_i = 1; step("R7 int clr");
    chk("R7 cleared", rdata_o & 8'hE0, 8'h00);
    // R6
    start_det_i = 1; step("R6 start");
    chk("R6 bit4 clr", rdata_o[4], 1'b0);
    gcall_match_i = 1; step("R9 regain bit1/2");
    master_i = 1; step("R6 master hold");
    chk("R6 hold", rdata_o & 8'h16, 8'h00);
    // R4 both conditions
    transmit_i = 1; sda_int_i = 1; sda_pin_i = 0; scl_rise_i = 1; step("R4 sda");
    chk("R4 sda", rdata_o[3], 1'b1);
    dr_wr_i = 1; step("R5 dr write tx");
    chk("R5 cleared", rdata_o[3], 1'b0);
    scl_int_i = 1; scl_fall_i = 1; step("R4 scl");
    chk("R4 scl", rdata_o[3], 1'b1);
    // R11: set and clear together
    scl_fall_i = 1; dr_wr_i = 1; step("R11 set wins");
    chk("R11", rdata_o[3], 1'b1);
    transmit_i = 0; scl_fall_i = 1; step("R4 not tx");
    dr_rd_i = 1; step("R5 dr read rx");
    chk("R5 rx clr", rdata_o[3], 1'b0);
    // R10
    transmit_i = 1; ack_sample_i = 1; ack_pin_i = 1; wr_i = 1; wdata_i = 8'h00;
    step("R10 ack capture");
    chk("R10", {7'd0, ack_o}, 8'h01);
    tdre_set_i = 1; step("R8 master cont");

    // R12: random mix against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) master_i = $urandom_range(1);
      if ($urandom_range(7) == 0) transmit_i = $urandom_range(1);
      fs_i = ($urandom_range(3) == 0); fsx_i = ($urandom_range(3) == 0);
      frame_busy_i = $urandom_range(1);
      sda_int_i = $urandom_range(1); sda_pin_i = $urandom_range(1);
      scl_int_i = $urandom_range(1); ack_pin_i = $urandom_range(1);
      start_det_i = ($urandom_range(15) == 0); stop_det_i = ($urandom_range(15) == 0);
      addr_match_i = ($urandom_range(7) == 0); gcall_match_i = ($urandom_range(7) == 0);
      addr2_match_i = ($urandom_range(7) == 0);
      tdre_set_i = ($urandom_range(7) == 0); rdrf_set_i = ($urandom_range(7) == 0);
      int_clr_i = ($urandom_range(15) == 0);
      dr_wr_i = ($urandom_range(7) == 0); dr_rd_i = ($urandom_range(7) == 0);
      scl_rise_i = ($urandom_range(3) == 0); scl_fall_i = ($urandom_range(3) == 0);
      ack_sample_i = ($urandom_range(7) == 0);
      rd_i = ($urandom_range(3) == 0); wr_i = ($urandom_range(3) == 0);
      wdata_i = 8'($urandom());
      step("R12 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule